// File: doc/BRIEF.md
# Page-latched EEPROM write controller

A byte-wide data EEPROM front end. The array is a register array of `2**ROW_W` rows of 32 bytes. Reads always return array contents through a registered read port, one cycle after the request.

Writes go through a 32-byte page buffer. Software first sets the latch bit in the control register. Array-region writes then land in the buffer slot picked by the five low address bits. The row comes from the high address bits of the latest buffered write. Setting the program bit starts a timed programming cycle that copies the written slots into that row. When the cycle ends, hardware clears both control bits at once.

The control register has its own select. It reads back as bit0 = latch, bit1 = program, bit2 = busy (busy equals program), bits 7:3 = 0.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After synchronous reset the control register reads 0x00 and `rdata` is 0x00. The array is not reset and starts at 0xFF.
- R2: With the latch bit at 0, array-region writes are dropped. An array read returns the byte at `addr` on `rdata` in the cycle after `rd`.
- R3: With the latch bit at 1, an array write is stored in buffer slot `addr[4:0]`. Reads still return the array contents, never the buffer.
- R4: A second write to a slot that is already flagged stores the bitwise AND of the old and new bytes.
- R5: The row programmed is `addr[AW-1:5]` of the most recent buffered write. Only flagged slots change the array, and the other bytes of that row keep their values.
- R6: A control write with bit0=1 and bit1=1, while the latch bit is already 1, starts programming. The control register then reads 0x07 for exactly `PROG_CYC` read cycles and 0x00 after that.
- R7: At the end of programming, the program bit and the latch bit clear in the same clock cycle.
- R8: All buffer flags are cleared at the end of programming and on every 1-to-0 change of the latch bit. Slots written earlier then neither program nor AND with later data.
- R9: While busy, array writes and control writes are ignored.
- R10: Setting the program bit while the latch bit is 0 has no effect, and the control register reads 0x00 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_sel | input | 1 | Access targets the array region |
| ctl_sel | input | 1 | Access targets the control register |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| addr | input | AW | Byte address in the array region (AW = ROW_W+5) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
Two situations are hard to reach from the ports. The first is a leftover buffer flag surviving into a later programming run, after the latch bit was dropped or a cycle completed. The stimulus writes a slot, clears the latch bit or finishes a cycle, and then programs new data into the same or a neighbouring slot. A stale flag would then show up as an AND-corrupted or unexpected byte in the array. The exact cycle length is measured by reading the control register on every cycle after the start command and checking where 0x07 turns into 0x00.

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl #(
  parameter int ROW_W    = 3,
  parameter int PROG_CYC = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   arr_sel,
  input  logic                   ctl_sel,
  input  logic                   wr,
  input  logic                   rd,
  input  logic [ROW_W+4:0]       addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata
);
  localparam int COL_W = 5;
  localparam int NSLOT = 1 << COL_W;
  localparam int AW    = ROW_W + COL_W;
  localparam int DEPTH = 1 << AW;
  localparam int CNT_W = $clog2(PROG_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYC - 1);

  logic [7:0]       mem  [DEPTH];
  logic [7:0]       pbuf [NSLOT];
  logic [NSLOT-1:0] flg;
  logic [ROW_W-1:0] row_q;
  logic             lat, pgm;
  logic [CNT_W-1:0] cnt;

  wire [COL_W-1:0] col    = addr[COL_W-1:0];
  wire             done   = pgm && (cnt == CNT_LAST);
  wire             ctl_wr = ctl_sel && wr && !pgm;
  wire             buf_wr = arr_sel && wr && lat && !pgm;
  wire             start  = ctl_wr && lat && wdata[0] && wdata[1];
  wire             drop   = ctl_wr && lat && !wdata[0];

  initial for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat   <= 1'b0;
      pgm   <= 1'b0;
      cnt   <= '0;
      flg   <= '0;
      row_q <= '0;
    end else if (done) begin
      lat <= 1'b0;
      pgm <= 1'b0;
      cnt <= '0;
      flg <= '0;
    end else if (pgm) begin
      cnt <= cnt + 1'b1;
    end else begin
      if (start) begin
        pgm <= 1'b1;
        cnt <= '0;
      end else if (ctl_wr) begin
        lat <= wdata[0];
      end
      if (drop) flg <= '0;
      else if (buf_wr) begin
        flg[col] <= 1'b1;
        row_q    <= addr[AW-1:COL_W];
      end
    end
  end

  always_ff @(posedge clk)
    if (buf_wr && !rst) pbuf[col] <= flg[col] ? (pbuf[col] & wdata) : wdata;

  always_ff @(posedge clk)
    if (done && !rst)
      for (int i = 0; i < NSLOT; i++)
        if (flg[i]) mem[{row_q, COL_W'(i)}] <= pbuf[i];

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else if (rd && ctl_sel) rdata <= {5'b0, pgm, pgm, lat};
    else if (rd && arr_sel) rdata <= mem[addr];
  end

  AST_END_CLEARS_BOTH: assert property (@(posedge clk) disable iff (rst)
    $fell(pgm) |-> (!lat && $past(lat)));                                    // R7
  AST_PGM_NEEDS_LAT: assert property (@(posedge clk) disable iff (rst)
    pgm |-> lat);                                                            // R10
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_LAST);                                                        // R6
  AST_LAT_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(lat) |-> (flg == '0));                                             // R8
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (pgm && $past(pgm)) |-> ($stable(flg) && $stable(row_q)));               // R9
  AST_NO_FLAG_WHEN_OPEN: assert property (@(posedge clk) disable iff (rst)
    !lat |-> (flg == '0));                                                   // R2
endmodule

// File: tb/test_eeprom_page_ctrl.sv
module test_eeprom_page_ctrl;
  localparam int ROW_W = 3;
  localparam int PC    = 16;
  localparam int AW    = ROW_W + 5;

  logic clk = 1'b0, rst = 1'b1;
  logic arr_sel = 0, ctl_sel = 0, wr = 0, rd = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;

  always #10 clk = ~clk;

  eeprom_page_ctrl #(.ROW_W(ROW_W), .PROG_CYC(PC)) i_eeprom_page_ctrl (
    .clk(clk), .rst(rst), .arr_sel(arr_sel), .ctl_sel(ctl_sel), .wr(wr),
    .rd(rd), .addr(addr), .wdata(wdata), .rdata(rdata));

  always @(posedge clk) pend <= rd;

  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic bus(input logic c, input logic w, input logic [AW-1:0] a, input logic [7:0] d);
    ctl_sel = c; arr_sel = !c; wr = w; rd = !w; addr = a; wdata = d;
    @(negedge clk);
    ctl_sel = 0; arr_sel = 0; wr = 0; rd = 0;
  endtask

  task automatic wr_arr(input int row, input int col, input logic [7:0] d);
    bus(1'b0, 1'b1, {row[ROW_W-1:0], col[4:0]}, d);
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    bus(1'b1, 1'b1, '0, d);
  endtask

  task automatic rd_arr(input int row, input int col, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus(1'b0, 1'b0, {row[ROW_W-1:0], col[4:0]}, 8'h00);
  endtask

  task automatic rd_ctl(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus(1'b1, 1'b0, '0, 8'h00);
  endtask

  task automatic prog_wait();
    repeat (PC + 2) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (rdata !== 8'h00) begin errors++; $display("FAIL R1: rdata %h expected 00", rdata); end
    rd_ctl(8'h00, "R1");
    rd_arr(5, 17, 8'hFF, "R1");

    wr_arr(0, 5, 8'h00);
    rd_arr(0, 5, 8'hFF, "R2");
    wr_ctl(8'h02);
    rd_ctl(8'h00, "R10");

    wr_ctl(8'h01);
    rd_ctl(8'h01, "R3");
    wr_arr(2, 3, 8'h5A);
    wr_arr(2, 3, 8'h0F);
    wr_arr(2, 7, 8'h33);
    rd_arr(2, 3, 8'hFF, "R3");
    wr_arr(3, 9, 8'h77);
    wr_ctl(8'h03);
    for (int i = 1; i <= PC + 1; i++)
      rd_ctl((i <= PC) ? 8'h07 : 8'h00, (i <= PC) ? "R6" : "R7");
    rd_arr(3, 3, 8'h0A, "R4");
    rd_arr(3, 7, 8'h33, "R5");
    rd_arr(3, 9, 8'h77, "R3");
    rd_arr(3, 10, 8'hFF, "R5");
    rd_arr(2, 3, 8'hFF, "R5");

    wr_ctl(8'h01);
    wr_arr(1, 0, 8'h12);
    wr_ctl(8'h00);
    rd_ctl(8'h00, "R8");
    wr_ctl(8'h01);
    wr_arr(1, 1, 8'h34);
    wr_ctl(8'h03);
    wr_arr(1, 2, 8'h99);
    wr_ctl(8'h00);
    rd_ctl(8'h07, "R9");
    prog_wait();
    rd_ctl(8'h00, "R7");
    rd_arr(1, 0, 8'hFF, "R8");
    rd_arr(1, 1, 8'h34, "R5");
    rd_arr(1, 2, 8'hFF, "R9");

    wr_ctl(8'h01);
    wr_arr(1, 1, 8'hF0);
    wr_ctl(8'h03);
    prog_wait();
    rd_arr(1, 1, 8'hF0, "R8");
    rd_arr(1, 0, 8'hFF, "R8");

    wr_ctl(8'h02);
    rd_ctl(8'h00, "R10");
    wr_arr(1, 1, 8'h00);
    rd_arr(1, 1, 8'hF0, "R2");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d reads unanswered, expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule